// File: doc/BRIEF.md
# Microwire serial EEPROM device model

This block is a synthesizable stand-in for a word-organised serial EEPROM that sits on a four-wire Microwire link: a chip select, a serial clock, a data input and a data output. A host controller, or a testbench for one, talks to it with ordinary command frames. The model decodes each frame into a read, a word write, a word erase, a whole-array write, a whole-array erase, or a change of the programming lock. It then acts on an internal array of 16-bit words.

All four pins are sampled with the system clock through a short synchroniser, so the serial clock must be several system clocks per phase. Programming has no real delay. A write or erase that has been fully received is committed a fixed number of system clocks after chip select falls. The address width is a parameter: 6 bits gives a 64-word array and 8 bits gives a 256-word array.

Top module: `mw_eeprom_model`

## Requirements
- R1: While chip select is high and no frame is in progress, 0 bits are skipped. The first 1 seen on a rising serial clock edge is the start bit, and the frame begins there.
- R2: After the start bit, the two opcode bits and ADDR_W address bits arrive MSB first. Opcode 10 is a read. From the rising edge that carries the last address bit, the data output shows one 0. Each later rising edge then presents the next bit of the addressed 16-bit word, MSB first.
- R3: Opcode 01 takes 16 data bits, MSB first, after the address. If programming is unlocked, it stores them in the addressed word.
- R4: Opcode 11 sets the addressed word to 16'hFFFF when programming is unlocked. Other words are untouched.
- R5: Opcode 00 is qualified by the two most significant address bits: 11 unlocks programming, 10 erases every word to 16'hFFFF, 01 writes the 16 data bits that follow into every word, and 00 locks programming. The lower address bits have no effect.
- R6: Programming is locked after reset, and the lock command locks it again. Write, erase, write-all and erase-all frames received while locked leave the array unchanged.
- R7: A received write or erase is committed only after chip select falls. It takes effect within COMMIT_DLY+4 system clocks of that fall, as a single one-cycle array update.
- R8: Dropping chip select before a frame is complete aborts it with no effect on the array. The next frame is decoded normally.
- R9: The data output is 0 whenever no read response is being shifted, and stays 0 after all 16 data bits of a read have been shifted out.
- R10: The address field is ADDR_W bits wide, and word n is reached only by address n. The lowest and highest addresses are distinct words.
- R11: Reset clears every word to 0 and drives the data output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host; rising edges shift bits |
| sdi | input | 1 | Serial command, address and data from the host |
| sdo | output | 1 | Serial read response to the host |

## Verification
The main read and write paths are swept across every address of the 64-word configuration. Each address gets a distinct arithmetic pattern, so a lost address bit, a swapped bit order or an aliased word shows up as a mismatch. The array-wide commands are then applied, with a constant fill for write-all and all ones for erase. These show whether every word, and not only the addressed one, is reached. Locked-state frames, special commands with arbitrary low address bits, start bits preceded by zeros and frames cut short by chip select each run against a known array content. This separates lock handling, opcode qualification, start detection and abort handling. Every read also checks the leading 0 and the quiet line after the last bit.

// File: rtl/mw_pkg.sv
// Package: shared codes and types for the serial EEPROM model.
// Assumes: opcode and extended-code values match the wire protocol.
package mw_pkg;

    // Two-bit opcode values as they appear on the wire
    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // Top two address bits that qualify OPC_EXT
    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_FILL   = 2'b01;
    localparam logic [1:0] EXT_CLEAR  = 2'b10;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;

    // Array update kinds passed from the decoder to the array
    typedef enum logic [2:0] {
        PROG_NONE,
        PROG_WORD,
        PROG_ERASE,
        PROG_FILL,
        PROG_CLEAR
    } prog_e;

    // Frame decoder states
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADDR,
        FS_DATA,
        FS_READ,
        FS_DONE
    } fstate_e;

endpackage

// File: rtl/mw_pin_sampler.sv
// Module: mw_pin_sampler
// Brings the asynchronous serial pins into the clk domain through
// SYNC_STAGES flops and flags each rising edge of the serial clock.
// Assumes: each serial clock phase lasts more than SYNC_STAGES+1 clk
// cycles, so no edge is lost; data and select share the clock's delay.
module mw_pin_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    input  logic sdi,
    output logic sel_q,
    output logic sdi_q,
    output logic sck_rise
);

    logic [SYNC_STAGES-1:0] sel_s;
    logic [SYNC_STAGES-1:0] sck_s;
    logic [SYNC_STAGES-1:0] sdi_s;
    logic                   sck_prev;

    // Shift every pin through its synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_s    <= '0;
            sck_s    <= '0;
            sdi_s    <= '0;
            sck_prev <= 1'b0;
        end else begin
            sel_s    <= {sel_s[SYNC_STAGES-2:0], sel};
            sck_s    <= {sck_s[SYNC_STAGES-2:0], sck};
            sdi_s    <= {sdi_s[SYNC_STAGES-2:0], sdi};
            sck_prev <= sck_s[SYNC_STAGES-1];
        end
    end

    // Present the aligned pin values and the serial clock rise flag
    always_comb begin
        sel_q    = sel_s[SYNC_STAGES-1];
        sdi_q    = sdi_s[SYNC_STAGES-1];
        sck_rise = sck_s[SYNC_STAGES-1] & ~sck_prev;
    end

endmodule

// File: rtl/mw_frame_decoder.sv
// Module: mw_frame_decoder
// Walks a command frame bit by bit: start bit, opcode, address, and
// data for the write kinds. It holds the programming lock, shifts read
// responses out with a leading 0, and raises a one-cycle request for
// every accepted write or erase.
// Assumes: sel_q, sdi_q and sck_rise come from the same sampler stage;
// rd_data is a combinational read of rd_addr.
module mw_frame_decoder
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_q,
    input  logic              sdi_q,
    input  logic              sck_rise,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sdo,
    output logic              rd_active,
    output logic              wen,
    output logic              req_valid,
    output prog_e             req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_data
);

    localparam int MAXF  = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
    localparam int CNT_W = $clog2(MAXF);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);

    fstate_e           state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] addr_sh;
    logic [WORD_W-1:0] data_sh;
    logic [WORD_W:0]   rd_sh;
    logic              fill_frame;
    logic [ADDR_W-1:0] full_addr;
    logic [1:0]        ext_code;

    // Address as it stands once the current input bit is included
    always_comb begin
        full_addr = {addr_sh[ADDR_W-2:0], sdi_q};
        ext_code  = full_addr[ADDR_W-1 -: 2];
        rd_addr   = full_addr;
    end

    // Frame state machine, shift registers and programming lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FS_IDLE;
            bit_cnt    <= '0;
            opc        <= '0;
            addr_sh    <= '0;
            data_sh    <= '0;
            rd_sh      <= '0;
            fill_frame <= 1'b0;
            wen        <= 1'b0;
            req_valid  <= 1'b0;
            req_kind   <= PROG_NONE;
            req_addr   <= '0;
            req_data   <= '0;
        end else begin
            req_valid <= 1'b0;
            if (!sel_q) begin
                state   <= FS_IDLE;
                bit_cnt <= '0;
                rd_sh   <= '0;
            end else if (sck_rise) begin
                case (state)
                    FS_IDLE: begin
                        if (sdi_q) begin
                            state   <= FS_OPC;
                            bit_cnt <= '0;
                        end
                    end
                    FS_OPC: begin
                        opc <= {opc[0], sdi_q};
                        if (bit_cnt == OPC_LAST) begin
                            state   <= FS_ADDR;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    FS_ADDR: begin
                        addr_sh <= full_addr;
                        if (bit_cnt == ADDR_LAST) begin
                            bit_cnt <= '0;
                            case (opc)
                                OPC_READ: begin
                                    rd_sh <= {1'b0, rd_data};
                                    state <= FS_READ;
                                end
                                OPC_WRITE: begin
                                    fill_frame <= 1'b0;
                                    state      <= FS_DATA;
                                end
                                OPC_ERASE: begin
                                    state <= FS_DONE;
                                    if (wen) begin
                                        req_valid <= 1'b1;
                                        req_kind  <= PROG_ERASE;
                                        req_addr  <= full_addr;
                                    end
                                end
                                default: begin
                                    case (ext_code)
                                        EXT_UNLOCK: begin
                                            wen   <= 1'b1;
                                            state <= FS_DONE;
                                        end
                                        EXT_LOCK: begin
                                            wen   <= 1'b0;
                                            state <= FS_DONE;
                                        end
                                        EXT_CLEAR: begin
                                            state <= FS_DONE;
                                            if (wen) begin
                                                req_valid <= 1'b1;
                                                req_kind  <= PROG_CLEAR;
                                            end
                                        end
                                        default: begin
                                            fill_frame <= 1'b1;
                                            state      <= FS_DATA;
                                        end
                                    endcase
                                end
                            endcase
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        data_sh <= {data_sh[WORD_W-2:0], sdi_q};
                        if (bit_cnt == DATA_LAST) begin
                            state <= FS_DONE;
                            if (wen) begin
                                req_valid <= 1'b1;
                                req_kind  <= fill_frame ? PROG_FILL : PROG_WORD;
                                req_addr  <= addr_sh;
                                req_data  <= {data_sh[WORD_W-2:0], sdi_q};
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    FS_READ: begin
                        rd_sh <= {rd_sh[WORD_W-1:0], 1'b0};
                    end
                    default: begin
                        state <= FS_DONE;
                    end
                endcase
            end
        end
    end

    // Read response drives the line only during the read phase
    always_comb begin
        rd_active = (state == FS_READ);
        sdo       = rd_active ? rd_sh[WORD_W] : 1'b0;
    end

endmodule

// File: rtl/mw_commit_timer.sv
// Module: mw_commit_timer
// Holds one accepted write or erase until chip select has been low for
// COMMIT_DLY cycles, then issues it to the array as a one-cycle update.
// Assumes: a new request cannot arrive while chip select is low.
module mw_commit_timer
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int WORD_W     = 16,
    parameter int COMMIT_DLY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_q,
    input  logic              req_valid,
    input  prog_e             req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              op_valid,
    output prog_e             op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [WORD_W-1:0] op_data
);

    localparam int DLY_W = $clog2(COMMIT_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(COMMIT_DLY - 1);

    logic              pend_valid;
    prog_e             pend_kind;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_data;
    logic [DLY_W-1:0]  dly_cnt;

    // Capture a request, count deselected cycles, then fire once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= PROG_NONE;
            pend_addr  <= '0;
            pend_data  <= '0;
            dly_cnt    <= '0;
            op_valid   <= 1'b0;
            op_kind    <= PROG_NONE;
            op_addr    <= '0;
            op_data    <= '0;
        end else begin
            op_valid <= 1'b0;
            if (req_valid) begin
                pend_valid <= 1'b1;
                pend_kind  <= req_kind;
                pend_addr  <= req_addr;
                pend_data  <= req_data;
                dly_cnt    <= '0;
            end else if (pend_valid && !sel_q) begin
                if (dly_cnt == DLY_LAST) begin
                    pend_valid <= 1'b0;
                    op_valid   <= 1'b1;
                    op_kind    <= pend_kind;
                    op_addr    <= pend_addr;
                    op_data    <= pend_data;
                    dly_cnt    <= '0;
                end else begin
                    dly_cnt <= dly_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mw_word_array.sv
// Module: mw_word_array
// Storage of 2**ADDR_W words with one combinational read port and one
// update port for single-word or whole-array writes and erases.
// Assumes: at most one update per cycle; erase means all ones.
module mw_word_array
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  prog_e             op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [WORD_W-1:0] op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  hit;
    logic              is_erase;
    logic [WORD_W-1:0] new_word;

    // Per-word select: the addressed word, or all words for array-wide kinds
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = op_valid &&
                        (((op_kind == PROG_WORD || op_kind == PROG_ERASE) &&
                          (op_addr == ADDR_W'(g))) ||
                         op_kind == PROG_FILL || op_kind == PROG_CLEAR);
    end

    // Value written into every selected word
    always_comb begin
        is_erase = (op_kind == PROG_ERASE) || (op_kind == PROG_CLEAR);
        new_word = is_erase ? {WORD_W{1'b1}} : op_data;
    end

    // Apply the update to the selected words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) mem[i] <= new_word;
            end
        end
    end

    // Combinational read port
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mw_eeprom_model.sv
// Module: mw_eeprom_model
// Top of the serial EEPROM model: pin sampler, frame decoder, commit
// timer and word array wired in a chain.
// Assumes: ADDR_W is 6 or 8; serial clock phases span several clk cycles.
module mw_eeprom_model
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int COMMIT_DLY  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    input  logic sdi,
    output logic sdo
);

    logic              sel_q;
    logic              sdi_q;
    logic              sck_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              rd_active;
    logic              wen;
    logic              req_valid;
    prog_e             req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic [WORD_W-1:0] req_data;
    logic              op_valid;
    prog_e             op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] op_data;

    mw_pin_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .sck      (sck),
        .sdi      (sdi),
        .sel_q    (sel_q),
        .sdi_q    (sdi_q),
        .sck_rise (sck_rise)
    );

    mw_frame_decoder #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_q     (sel_q),
        .sdi_q     (sdi_q),
        .sck_rise  (sck_rise),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sdo       (sdo),
        .rd_active (rd_active),
        .wen       (wen),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_data  (req_data)
    );

    mw_commit_timer #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .COMMIT_DLY(COMMIT_DLY)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_q     (sel_q),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    mw_word_array #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mw_eeprom_checker.sv
// Module: mw_eeprom_checker
// Protocol properties of the EEPROM model, bound into its top.
// Assumes: two synchroniser stages between the pins and the decoder.
module mw_eeprom_checker (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic sdo,
    input logic sel_q,
    input logic rd_active,
    input logic op_valid
);

    AST_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !sel_q); // R7

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R7

    AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !sdo); // R2

    AST_LINE_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel) && !$past(sel, 2) && !$past(sel, 3)) |-> !sdo); // R8

endmodule

bind mw_eeprom_model mw_eeprom_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .sdo       (sdo),
    .sel_q     (sel_q),
    .rd_active (rd_active),
    .op_valid  (op_valid)
);

// File: tb/sim_mw_eeprom_model.sv
module sim_mw_eeprom_model;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [DEPTH];

    mw_eeprom_model #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi), .sdo(sdo)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h1357) ^ 16'hA5C3);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        repeat (4) @(negedge clk);
        b = sdo;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_on();
        sel = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        sel = 1'b0;
        sdi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input int addr, input bit has_data,
                            input logic [15:0] d);
        cs_on();
        put_bit(1'b1);
        put_bit(op[1]);
        put_bit(op[0]);
        for (int i = AW - 1; i >= 0; i--) put_bit(addr[i]);
        if (has_data) for (int i = 15; i >= 0; i--) put_bit(d[i]);
        cs_off();
    endtask

    task automatic read_word(input int addr, output logic lead, output logic [15:0] w,
                             output logic tail);
        logic b;
        cs_on();
        put_bit(1'b1);
        put_bit(1'b1);
        put_bit(1'b0);
        for (int i = AW - 1; i >= 0; i--) put_bit(addr[i]);
        get_bit(lead);
        for (int i = 15; i >= 0; i--) begin
            get_bit(b);
            w[i] = b;
        end
        get_bit(tail);
        cs_off();
    endtask

    task automatic verify(input int addr, input string req);
        logic lead, tail;
        logic [15:0] w;
        read_word(addr, lead, w, tail);
        check(lead == 1'b0, "R2 leading zero", 32'(lead), 32'h0);
        check(w == model[addr], req, 32'(w), 32'(model[addr]));
        check(tail == 1'b0, "R9 line low after word", 32'(tail), 32'h0);
    endtask

    task automatic verify_all(input string req);
        for (int a = 0; a < DEPTH; a++) verify(a, req);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo == 1'b0, "R11 sdo after reset", 32'(sdo), 32'h0);
        verify(0, "R11 word 0 after reset");
        verify(DEPTH - 1, "R11 top word after reset");

        // R6: locked after reset
        send_cmd(2'b01, 5, 1'b1, 16'h1234);
        verify(5, "R6 write while locked");
        send_cmd(2'b00, 6'b01_0000, 1'b1, 16'h7777);
        send_cmd(2'b00, 6'b10_0000, 1'b0, 16'h0);
        verify(5, "R6 fill/clear while locked");

        // R5 unlock with arbitrary low bits; R3 and R10 sweep
        send_cmd(2'b00, 6'b11_0101, 1'b0, 16'h0);
        for (int a = 0; a < DEPTH; a++) begin
            send_cmd(2'b01, a, 1'b1, pat(a));
            model[a] = pat(a);
        end
        verify_all("R3 R10 word write sweep");

        // R1: zeros before the start bit
        cs_on();
        put_bit(1'b0);
        put_bit(1'b0);
        put_bit(1'b0);
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        for (int i = AW - 1; i >= 0; i--) put_bit(7 >> i);
        for (int i = 15; i >= 0; i--) put_bit(16'hBEEF >> i);
        cs_off();
        model[7] = 16'hBEEF;
        verify(7, "R1 start after zeros");

        // R4: erase one word, neighbour untouched; R7 read right after commit
        send_cmd(2'b11, 9, 1'b0, 16'h0);
        model[9] = 16'hFFFF;
        verify(9, "R4 R7 erase word");
        verify(10, "R4 neighbour kept");

        // R8: abort in the data phase, then a normal frame
        cs_on();
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        for (int i = AW - 1; i >= 0; i--) put_bit(3 >> i);
        for (int i = 0; i < 10; i++) put_bit(1'b1);
        cs_off();
        verify(3, "R8 aborted write");
        check(sdo == 1'b0, "R8 line idle", 32'(sdo), 32'h0);

        // R5: fill then clear the whole array
        send_cmd(2'b00, 6'b01_1011, 1'b1, 16'h3C5A);
        for (int a = 0; a < DEPTH; a++) model[a] = 16'h3C5A;
        verify_all("R5 fill all");
        send_cmd(2'b00, 6'b10_0110, 1'b0, 16'h0);
        for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
        verify_all("R5 clear all");

        // R6 and R5: lock with arbitrary low bits, programming ignored
        send_cmd(2'b00, 6'b00_1110, 1'b0, 16'h0);
        send_cmd(2'b01, 0, 1'b1, 16'h0000);
        send_cmd(2'b00, 6'b01_0001, 1'b1, 16'h1111);
        verify(0, "R6 write after lock");
        verify(DEPTH - 1, "R6 fill after lock");
        check(sdo == 1'b0, "R9 idle between frames", 32'(sdo), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule